// File: doc/BRIEF.md
# Nine-Bit-Lane True Dual-Port RAM

This block is a synthesizable model of a true dual-port memory. Two ports, A and B, share one storage array. Each port has its own clock, reset, enable, per-lane write enables, address, write data and read data, and the two ports operate at the same time without depending on each other. A data word is made of nine-bit lanes. Each lane holds one byte plus one extra storage bit that the user may use for any purpose. The block does not generate or check parity.

Every access on an enabled port also reads the addressed word. A per-port mode parameter selects what the registered output shows during a write: the old word, the newly written data, or the previous output unchanged. Each port can add an optional second output register, which adds one cycle of latency. The output reset clears only the output registers and leaves the array contents intact. The array can start with zeros, with a constant in every lane, or with each lane equal to its own word address.

When both ports are enabled on the same address and at least one of them writes, the data is undefined. The block raises a collision flag on each port, aligned with the affected output. The affected outputs show either a filler lane value or X, as chosen by a parameter. The ports use plain synchronous control and have no handshake. An access is accepted on every clock edge where its enable is high.

Top module: `lane9_dual_port_ram`

## Requirements
- R1: The two ports operate concurrently. In the same cycle, port A can write one address while port B reads a different address, and each port gets its own correct result.
- R2: In read-first mode, an enabled port with no collision outputs the word as it was before that cycle's write.
- R3: In write-first mode, a lane that is written this cycle appears on the output with its new nine-bit value.
- R4: In write-first mode, during a partial write, each lane that is not written shows the filler lane value (parameter `FILL_LANE`, default 9'h000) when `UNDEF_X` is 0.
- R5: In no-change mode, an enabled write leaves the output register unchanged.
- R6: Write-enable bit i covers lane i, which is data bits [9i+8:9i], including the ninth bit. A lane whose enable is low keeps its stored value.
- R7: Without the pipeline stage, read data is valid after the first clock edge that follows the access. With the pipeline stage (`PIPE_*`=1), it is valid after the second clock edge.
- R8: When a port's enable is low, that port neither reads nor writes, and its output register and collision flag hold their values.
- R9: A synchronous reset clears the port's output registers and collision flag to 0. The reset takes effect whether or not the port is enabled, and it leaves the array contents unchanged.
- R10: With `INIT_KIND`=INIT_ADDR (the default), every lane of word w initially holds w, truncated or zero-extended to nine bits.
- R11: When both ports are enabled on the same address and at least one of them writes, each port's collision flag goes to 1 with that access's output, and that output shows filler lanes. A word written only by port B in such a cycle still stores B's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous output-register reset |
| en_a | input | 1 | Port A access enable |
| we_a | input | LANES | Port A per-lane write enables |
| addr_a | input | $clog2(DEPTH) | Port A word address |
| din_a | input | 9*LANES | Port A write data |
| dout_a | output | 9*LANES | Port A registered read data |
| collide_a | output | 1 | Port A same-address collision flag, aligned with dout_a |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous output-register reset |
| en_b | input | 1 | Port B access enable |
| we_b | input | LANES | Port B per-lane write enables |
| addr_b | input | $clog2(DEPTH) | Port B word address |
| din_b | input | 9*LANES | Port B write data |
| dout_b | output | 9*LANES | Port B registered read data |
| collide_b | output | 1 | Port B same-address collision flag, aligned with dout_b |

## Verification
The assertions assume the following about the inputs:
- Write-first lane checks and no-change hold checks assume the two ports' clocks sample one another's addresses at the same edge. The collision detector only has meaning under that assumption.
- The pipeline-delay check assumes reset is not asserted in the cycle in which the property starts.

The stimulus stays within these assumptions as follows:
- Both ports are driven from one shared clock.
- Inputs change only at the falling edge.
- Reset is pulsed only while both ports are idle.
- Collisions are produced in exactly one deliberate cycle. Every other cycle in which both ports are active uses distinct addresses.

// File: rtl/lane9_ram_pkg.sv
package lane9_ram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;

  typedef enum logic [1:0] {
    INIT_ZERO  = 2'd0,
    INIT_CONST = 2'd1,
    INIT_ADDR  = 2'd2
  } init_kind_e;
endpackage

// File: rtl/lane9_ram_bank.sv
module lane9_ram_bank
  import lane9_ram_pkg::*;
#(
  parameter int         LANES     = 4,
  parameter int         DEPTH     = 512,
  parameter bit         PRELOAD   = 1'b1,
  parameter init_kind_e INIT_KIND = INIT_ADDR,
  parameter logic [LANE_W-1:0] INIT_LANE = '0,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANE_W * LANES
) (
  input  logic             clk,
  input  logic [LANES-1:0] lane_wr,
  input  logic [AW-1:0]    addr_w,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    partner_w,
  input  logic [AW-1:0]    addr_x,
  output logic [DW-1:0]    word_w,
  output logic [DW-1:0]    word_x
);
  // One half of an XOR-split array: the logical word is the XOR of both
  // halves, so each half has exactly one writing clock.
  logic [DW-1:0] store [DEPTH];

  function automatic logic [DW-1:0] start_word(input int idx);
    logic [DW-1:0]     w;
    logic [LANE_W-1:0] lv;
    lv = '0;
    if (PRELOAD) begin
      case (INIT_KIND)
        INIT_CONST: lv = INIT_LANE;
        INIT_ADDR:  lv = LANE_W'(idx);
        default:    lv = '0;
      endcase
    end
    w = {LANES{lv}};
    return w;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = start_word(i);
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_wr[l])
        store[addr_w][l*LANE_W +: LANE_W] <=
          wdata[l*LANE_W +: LANE_W] ^ partner_w[l*LANE_W +: LANE_W];
    end
  end

  assign word_w = store[addr_w];
  assign word_x = store[addr_x];
endmodule

// File: rtl/lane9_ram_collide.sv
module lane9_ram_collide #(
  parameter int LANES = 4,
  parameter int AW    = 9
) (
  input  logic             en_a,
  input  logic [LANES-1:0] we_a,
  input  logic [AW-1:0]    addr_a,
  input  logic             en_b,
  input  logic [LANES-1:0] we_b,
  input  logic [AW-1:0]    addr_b,
  output logic             hit
);
  logic same_word;
  logic any_write;
  assign same_word = en_a && en_b && (addr_a == addr_b);
  assign any_write = (|we_a) || (|we_b);
  assign hit       = same_word && any_write;
endmodule

// File: rtl/lane9_ram_port.sv
module lane9_ram_port
  import lane9_ram_pkg::*;
#(
  parameter int       LANES   = 4,
  parameter wr_mode_e MODE    = WM_READ_FIRST,
  parameter bit       PIPE    = 1'b0,
  parameter bit       UNDEF_X = 1'b0,
  parameter logic [LANE_W-1:0] FILL_LANE = '0,
  localparam int DW = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LANES-1:0] we,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    old_word,
  input  logic             collide,
  output logic [DW-1:0]    dout,
  output logic             col_out
);
  localparam logic [LANE_W-1:0] PAD = UNDEF_X ? {LANE_W{1'bx}} : FILL_LANE;

  logic [DW-1:0] nxt;
  logic [DW-1:0] dq1;
  logic          col_q1;

  always_comb begin
    nxt = old_word;
    if (|we) begin
      case (MODE)
        WM_WRITE_FIRST: begin
          for (int l = 0; l < LANES; l++)
            nxt[l*LANE_W +: LANE_W] = we[l] ? din[l*LANE_W +: LANE_W] : PAD;
        end
        WM_NO_CHANGE: nxt = dq1;
        default:      nxt = old_word;
      endcase
    end
    if (collide) nxt = {LANES{PAD}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq1    <= '0;
      col_q1 <= 1'b0;
    end else if (en) begin
      dq1    <= nxt;
      col_q1 <= collide;
    end
  end

  generate
    if (PIPE) begin : g_pipe
      logic [DW-1:0] dq2;
      logic          col_q2;
      always_ff @(posedge clk) begin
        if (rst) begin
          dq2    <= '0;
          col_q2 <= 1'b0;
        end else begin
          dq2    <= dq1;
          col_q2 <= col_q1;
        end
      end
      assign dout    = dq2;
      assign col_out = col_q2;

      AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (dout == $past(dq1)));  // R7
    end else begin : g_direct
      assign dout    = dq1;
      assign col_out = col_q1;
    end

    if (MODE == WM_NO_CHANGE) begin : g_nc_chk
      AST_NC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && (|we) && !collide) |=> $stable(dq1));  // R5
    end

    if (MODE == WM_WRITE_FIRST) begin : g_wf_chk
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        AST_WF_NEW_LANE: assert property (@(posedge clk) disable iff (rst)
          (en && we[l] && !collide) |=>
            (dq1[l*LANE_W +: LANE_W] == $past(din[l*LANE_W +: LANE_W])));  // R3
      end
    end
  endgenerate

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dq1) && $stable(col_q1)));  // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (dq1 == '0 && !col_q1));  // R9

  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (en && collide) |=> col_q1);  // R11
endmodule

// File: rtl/lane9_dual_port_ram.sv
module lane9_dual_port_ram
  import lane9_ram_pkg::*;
#(
  parameter int         LANES     = 4,
  parameter int         DEPTH     = 512,
  parameter wr_mode_e   MODE_A    = WM_READ_FIRST,
  parameter wr_mode_e   MODE_B    = WM_WRITE_FIRST,
  parameter bit         PIPE_A    = 1'b0,
  parameter bit         PIPE_B    = 1'b1,
  parameter init_kind_e INIT_KIND = INIT_ADDR,
  parameter logic [LANE_W-1:0] INIT_LANE = '0,
  parameter bit         UNDEF_X   = 1'b0,
  parameter logic [LANE_W-1:0] FILL_LANE = '0,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANE_W * LANES
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic             en_a,
  input  logic [LANES-1:0] we_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [DW-1:0]    din_a,
  output logic [DW-1:0]    dout_a,
  output logic             collide_a,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic             en_b,
  input  logic [LANES-1:0] we_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [DW-1:0]    din_b,
  output logic [DW-1:0]    dout_b,
  output logic             collide_b
);
  logic [DW-1:0]    ha_at_a, ha_at_b, hb_at_a, hb_at_b;
  logic [DW-1:0]    old_a, old_b;
  logic [LANES-1:0] wr_a, wr_b;
  logic             hit;

  assign wr_a  = en_a ? we_a : '0;
  assign wr_b  = en_b ? we_b : '0;
  assign old_a = ha_at_a ^ hb_at_a;
  assign old_b = ha_at_b ^ hb_at_b;

  lane9_ram_bank #(
    .LANES(LANES), .DEPTH(DEPTH), .PRELOAD(1'b1),
    .INIT_KIND(INIT_KIND), .INIT_LANE(INIT_LANE)
  ) u_half_a (
    .clk(clk_a), .lane_wr(wr_a), .addr_w(addr_a), .wdata(din_a),
    .partner_w(hb_at_a), .addr_x(addr_b), .word_w(ha_at_a), .word_x(ha_at_b)
  );

  lane9_ram_bank #(
    .LANES(LANES), .DEPTH(DEPTH), .PRELOAD(1'b0),
    .INIT_KIND(INIT_KIND), .INIT_LANE(INIT_LANE)
  ) u_half_b (
    .clk(clk_b), .lane_wr(wr_b), .addr_w(addr_b), .wdata(din_b),
    .partner_w(ha_at_b), .addr_x(addr_a), .word_w(hb_at_b), .word_x(hb_at_a)
  );

  lane9_ram_collide #(.LANES(LANES), .AW(AW)) u_collide (
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .hit(hit)
  );

  lane9_ram_port #(
    .LANES(LANES), .MODE(MODE_A), .PIPE(PIPE_A),
    .UNDEF_X(UNDEF_X), .FILL_LANE(FILL_LANE)
  ) u_port_a (
    .clk(clk_a), .rst(rst_a), .en(en_a), .we(we_a), .din(din_a),
    .old_word(old_a), .collide(hit), .dout(dout_a), .col_out(collide_a)
  );

  lane9_ram_port #(
    .LANES(LANES), .MODE(MODE_B), .PIPE(PIPE_B),
    .UNDEF_X(UNDEF_X), .FILL_LANE(FILL_LANE)
  ) u_port_b (
    .clk(clk_b), .rst(rst_b), .en(en_b), .we(we_b), .din(din_b),
    .old_word(old_b), .collide(hit), .dout(dout_b), .col_out(collide_b)
  );

  AST_WRITE_LANDS_A: assert property (@(posedge clk_a) disable iff (rst_a)
    (en_a && (&we_a) && !hit) |=> ((ha_at_a ^ hb_at_a) == $past(din_a)
      || addr_a != $past(addr_a)));  // R6
endmodule

// File: tb/lane9_dual_port_ram_test.sv
module lane9_dual_port_ram_test;
  import lane9_ram_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_a, en_a, rst_b, en_b;
  logic [3:0]  we_a, we_b;
  logic [8:0]  addr_a, addr_b;
  logic [35:0] din_a, din_b, dout_a, dout_b;
  logic        collide_a, collide_b;

  logic        nc_en;
  logic [3:0]  nc_we;
  logic [8:0]  nc_addr;
  logic [35:0] nc_din, nc_dout, nc_dout_b;
  logic        nc_col_a, nc_col_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  lane9_dual_port_ram uut (
    .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(dout_a), .collide_a(collide_a),
    .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(dout_b), .collide_b(collide_b)
  );

  lane9_dual_port_ram #(.MODE_A(WM_NO_CHANGE), .PIPE_A(1'b0)) uut_nc (
    .clk_a(clk), .rst_a(rst_a), .en_a(nc_en), .we_a(nc_we), .addr_a(nc_addr),
    .din_a(nc_din), .dout_a(nc_dout), .collide_a(nc_col_a),
    .clk_b(clk), .rst_b(rst_b), .en_b(1'b0), .we_b(4'h0), .addr_b(9'd0),
    .din_b(36'h0), .dout_b(nc_dout_b), .collide_b(nc_col_b)
  );

  typedef struct packed {
    logic [3:0]  we;
    logic [8:0]  addr;
    logic [35:0] din;
    logic [35:0] exp;
  } vec_t;

  // Port A: read-first, no pipeline; one cycle per entry.
  localparam vec_t VECS [11] = '{
    '{4'h0, 9'd5,   36'h0, {4{9'h005}}},                          // R10
    '{4'hF, 9'd5,   {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4}, {4{9'h005}}}, // R2
    '{4'h0, 9'd5,   36'h0, {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4}},
    '{4'h1, 9'd5,   {9'h111, 9'h122, 9'h133, 9'h1FF},
                    {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4}},              // R2
    '{4'h0, 9'd5,   36'h0, {9'h1A1, 9'h0B2, 9'h1C3, 9'h1FF}},       // R6
    '{4'hA, 9'd7,   {9'h1EE, 9'h0DD, 9'h1CC, 9'h0BB}, {4{9'h007}}}, // R2
    '{4'h0, 9'd7,   36'h0, {9'h1EE, 9'h007, 9'h1CC, 9'h007}},       // R6
    '{4'h0, 9'd511, 36'h0, {4{9'h1FF}}},                          // R10
    '{4'hF, 9'd0,   {4{9'h100}}, {4{9'h000}}},
    '{4'h0, 9'd0,   36'h0, {4{9'h100}}},                          // R6
    '{4'h0, 9'd5,   36'h0, {9'h1A1, 9'h0B2, 9'h1C3, 9'h1FF}}
  };

  localparam logic [35:0] E1 = {9'h155, 9'h0AA, 9'h133, 9'h0CC};
  localparam logic [35:0] F1 = {9'h0F1, 9'h1F2, 9'h0F3, 9'h1F4};
  localparam logic [35:0] G1 = {9'h1AB, 9'h1CD, 9'h0EF, 9'h123};
  localparam logic [35:0] H1 = {9'h1DE, 9'h0AD, 9'h1BE, 9'h0EF};
  localparam logic [35:0] K1 = {9'h1F0, 9'h00F, 9'h1E1, 9'h01E};

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_a(input logic en, input logic [3:0] we,
                         input logic [8:0] addr, input logic [35:0] din);
    en_a = en; we_a = we; addr_a = addr; din_a = din;
  endtask

  task automatic drive_b(input logic en, input logic [3:0] we,
                         input logic [8:0] addr, input logic [35:0] din);
    en_b = en; we_b = we; addr_b = addr; din_b = din;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_a = 1'b1; rst_b = 1'b1;
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    nc_en = 1'b0; nc_we = 4'h0; nc_addr = 9'd0; nc_din = 36'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_a = 1'b0; rst_b = 1'b0;
    step();
    // R9: outputs come out of reset cleared
    check("R9 reset dout_a", dout_a, 36'h0);
    check("R9 reset dout_b", dout_b, 36'h0);
    check("R9 reset collide", {34'h0, collide_a, collide_b}, 36'h0);

    // Vector table on port A (R2, R6, R7, R10)
    for (int i = 0; i < 11; i++) begin
      drive_a(1'b1, VECS[i].we, VECS[i].addr, VECS[i].din);
      step();
      check($sformatf("R2/R7 vector %0d", i), dout_a, VECS[i].exp);
    end
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);

    // R1: A writes 20 while B reads 7 in the same cycle
    drive_a(1'b1, 4'hF, 9'd20, E1);
    drive_b(1'b1, 4'h0, 9'd7, 36'h0);
    step();
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    step();
    check("R1 B read during A write", dout_b, {9'h1EE, 9'h007, 9'h1CC, 9'h007});
    drive_a(1'b1, 4'h0, 9'd20, 36'h0);
    step();
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    check("R1 A write landed", dout_a, E1);

    // R3 and R7: B write-first, pipelined
    drive_b(1'b1, 4'hF, 9'd30, F1);
    step();
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    check("R7 pipe not yet updated", dout_b, {9'h1EE, 9'h007, 9'h1CC, 9'h007});
    step();
    check("R3 write-first full", dout_b, F1);

    // R4: partial write-first shows filler in unwritten lanes
    drive_b(1'b1, 4'h3, 9'd30, G1);
    step();
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    step();
    check("R4 partial write-first", dout_b, {9'h000, 9'h000, 9'h0EF, 9'h123});
    drive_b(1'b1, 4'h0, 9'd30, 36'h0);
    step();
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    step();
    check("R6 partial lanes stored", dout_b, {9'h0F1, 9'h1F2, 9'h0EF, 9'h123});

    // R8: disabled port neither writes nor updates its output
    drive_a(1'b0, 4'hF, 9'd5, {36{1'b1}});
    step();
    check("R8 output held", dout_a, E1);
    drive_a(1'b1, 4'h0, 9'd5, 36'h0);
    step();
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    check("R8 no write while disabled", dout_a, {9'h1A1, 9'h0B2, 9'h1C3, 9'h1FF});

    // R11: A reads 40 while B writes 40
    drive_a(1'b1, 4'h0, 9'd40, 36'h0);
    drive_b(1'b1, 4'hF, 9'd40, H1);
    step();
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    check("R11 collide_a", {35'h0, collide_a}, 36'h1);
    check("R11 dout_a filler", dout_a, 36'h0);
    step();
    check("R11 collide_b", {35'h0, collide_b}, 36'h1);
    check("R11 dout_b filler", dout_b, 36'h0);
    drive_a(1'b1, 4'h0, 9'd40, 36'h0);
    step();
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    check("R11 B data stored", dout_a, H1);
    check("R11 flag clears", {35'h0, collide_a}, 36'h0);

    // R9: reset mid-run clears outputs only
    rst_a = 1'b1; rst_b = 1'b1;
    step();
    rst_a = 1'b0; rst_b = 1'b0;
    check("R9 dout_a cleared", dout_a, 36'h0);
    check("R9 dout_b cleared", dout_b, 36'h0);
    check("R9 collide_b cleared", {35'h0, collide_b}, 36'h0);
    drive_a(1'b1, 4'h0, 9'd40, 36'h0);
    drive_b(1'b1, 4'h0, 9'd20, 36'h0);
    step();
    drive_a(1'b0, 4'h0, 9'd0, 36'h0);
    drive_b(1'b0, 4'h0, 9'd0, 36'h0);
    check("R9 array kept A", dout_a, H1);
    step();
    check("R9 array kept B", dout_b, E1);

    // R5: no-change mode instance
    nc_en = 1'b1; nc_we = 4'h0; nc_addr = 9'd3; nc_din = 36'h0;
    step();
    check("R10 nc init word", nc_dout, {4{9'h003}});
    nc_we = 4'hF; nc_din = K1;
    step();
    check("R5 no-change hold", nc_dout, {4{9'h003}});
    nc_we = 4'h0; nc_din = 36'h0;
    step();
    nc_en = 1'b0;
    check("R5 no-change write stored", nc_dout, K1);

    finish_run();
  end
endmodule